// File: doc/BRIEF.md
# Belt Operand Liveness Tracker

This block tracks which logical belt positions currently hold a live operand. It keeps a fixed-length queue of slots. Position 0 is the newest result and the highest position is the oldest. Each slot holds a physical operand tag, the frame that owns the operand, and a live flag. Operand values themselves are stored elsewhere. The tracker only maps logical positions to tags and decides when each tag stops being live.

A result that is accepted enters position 0 and pushes every older slot one step along. The slot pushed past the end is reported on the eviction output. Control-flow events also change liveness:

- A call keeps only its argument positions live.
- A return kills the operands owned by the frame that is exiting.
- A branch keeps the slots chosen by a mask and packs them toward position 0.

A result tagged with a frame deeper than the current one belongs to a frame that has already returned. Such a result is dead on arrival and is never placed. A result from an outer (caller) frame that completes while a callee runs is placed with its own frame tag.

Top module: `belt_tracker`

## Requirements
- R1: After reset, every position reads invalid, the current frame is 0 and no eviction is reported.
- R2: An accepted drop puts its tag and frame at position 0 and moves each older slot from position i to i+1. A lookup shows the new state in the cycle after the clock edge that takes the drop.
- R3: When an accepted drop pushes a valid slot out of the last position, evict_valid_o is 1 for the cycle after that edge and evict_tag_o carries that slot's tag. In every other case evict_valid_o is 0.
- R4: A call with argument count N keeps positions below N unchanged, makes every position at N or above invalid, and increases the current frame by 1.
- R5: A return makes invalid every slot whose frame equals the current frame. It then decreases the current frame by 1, but the frame stays at 0 if it is already 0.
- R6: A branch keeps position i only when bit i of the keep mask is 1 and the slot is valid. The surviving slots are packed into positions 0 upward in their original order, and all positions above them become invalid.
- R7: A drop whose frame is greater than the current frame (the value before any event in the same cycle) is discarded. It causes no shift, no change to any position and no eviction.
- R8: A drop whose frame is less than the current frame is accepted and stores its own frame, not the current frame. The stored frame is visible on rd_frame_o.
- R9: A lookup of an invalid position returns rd_valid_o = 0 and rd_err_o = 1. A lookup of a valid position returns rd_err_o = 0.
- R10: In one cycle, at most one control event takes effect, in the priority call, then return, then branch. A drop in the same cycle is applied after that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drop_valid_i | input | 1 | A new result is offered |
| drop_tag_i | input | TAG_W | Physical tag of the result |
| drop_frame_i | input | FRAME_W | Frame that owns the result |
| call_valid_i | input | 1 | Call event |
| call_argc_i | input | $clog2(BELT_LEN+1) | Number of argument positions kept by the call |
| ret_valid_i | input | 1 | Return event |
| br_valid_i | input | 1 | Branch event |
| br_keep_i | input | BELT_LEN | Bit i keeps position i |
| rd_pos_i | input | $clog2(BELT_LEN) | Logical position to look up |
| rd_valid_o | output | 1 | Looked-up position is live |
| rd_err_o | output | 1 | Looked-up position is not live |
| rd_tag_o | output | TAG_W | Tag at the looked-up position |
| rd_frame_o | output | FRAME_W | Frame at the looked-up position |
| evict_valid_o | output | 1 | A live slot left the last position |
| evict_tag_o | output | TAG_W | Tag of the evicted slot |
| cur_frame_o | output | FRAME_W | Current issue frame |

## Verification
The slot state is registered, and a lookup is combinational on that state. The effect of any event can therefore be read from one nanosecond after the rising edge that takes it. The bench steps through every position before the next falling edge. The eviction output is registered once, so it is due for exactly the one cycle after the edge that takes the drop. The monitor samples it at that falling edge and compares it with the head of a queue that the driver fills just after the same edge. A missing eviction, an extra eviction or a wrong tag is therefore caught in the cycle where it occurs.

// File: rtl/belt_pkg.sv
package belt_pkg;
  typedef enum logic [1:0] {
    CTL_NONE = 2'd0,
    CTL_CALL = 2'd1,
    CTL_RET  = 2'd2,
    CTL_BR   = 2'd3
  } ctl_op_e;

  function automatic ctl_op_e pick_ctl(input logic call_v, input logic ret_v, input logic br_v);
    if (call_v)     return CTL_CALL;
    else if (ret_v) return CTL_RET;
    else if (br_v)  return CTL_BR;
    else            return CTL_NONE;
  endfunction
endpackage

// File: rtl/belt_compact.sv
module belt_compact #(
  parameter int BELT_LEN = 8,
  parameter int TAG_W    = 6,
  parameter int FRAME_W  = 4
) (
  input  logic [BELT_LEN-1:0] keep_i,
  input  logic                v_i [BELT_LEN],
  input  logic [TAG_W-1:0]    t_i [BELT_LEN],
  input  logic [FRAME_W-1:0]  f_i [BELT_LEN],
  output logic                v_o [BELT_LEN],
  output logic [TAG_W-1:0]    t_o [BELT_LEN],
  output logic [FRAME_W-1:0]  f_o [BELT_LEN]
);
  localparam int IW = (BELT_LEN > 1) ? $clog2(BELT_LEN) : 1;

  // survivors slide down in order; cnt never exceeds i
  always_comb begin
    logic [IW-1:0] cnt;
    cnt = '0;
    for (int j = 0; j < BELT_LEN; j++) begin
      v_o[j] = 1'b0;
      t_o[j] = '0;
      f_o[j] = '0;
    end
    for (int i = 0; i < BELT_LEN; i++) begin
      if (v_i[i] && keep_i[i]) begin
        v_o[cnt] = 1'b1;
        t_o[cnt] = t_i[i];
        f_o[cnt] = f_i[i];
        cnt = cnt + IW'(1);
      end
    end
  end
endmodule

// File: rtl/belt_ctl_stage.sv
module belt_ctl_stage
  import belt_pkg::*;
#(
  parameter int BELT_LEN = 8,
  parameter int TAG_W    = 6,
  parameter int FRAME_W  = 4,
  localparam int AW      = $clog2(BELT_LEN + 1)
) (
  input  ctl_op_e             op_i,
  input  logic [AW-1:0]       argc_i,
  input  logic [BELT_LEN-1:0] keep_i,
  input  logic [FRAME_W-1:0]  cur_frame_i,
  input  logic                v_i [BELT_LEN],
  input  logic [TAG_W-1:0]    t_i [BELT_LEN],
  input  logic [FRAME_W-1:0]  f_i [BELT_LEN],
  output logic                v_o [BELT_LEN],
  output logic [TAG_W-1:0]    t_o [BELT_LEN],
  output logic [FRAME_W-1:0]  f_o [BELT_LEN]
);
  logic                cv [BELT_LEN];
  logic [TAG_W-1:0]    ct [BELT_LEN];
  logic [FRAME_W-1:0]  cf [BELT_LEN];

  belt_compact #(.BELT_LEN(BELT_LEN), .TAG_W(TAG_W), .FRAME_W(FRAME_W)) u_compact (
    .keep_i (keep_i),
    .v_i    (v_i),
    .t_i    (t_i),
    .f_i    (f_i),
    .v_o    (cv),
    .t_o    (ct),
    .f_o    (cf)
  );

  for (genvar g = 0; g < BELT_LEN; g++) begin : g_slot
    always_comb begin
      v_o[g] = v_i[g];
      t_o[g] = t_i[g];
      f_o[g] = f_i[g];
      unique case (op_i)
        CTL_CALL: v_o[g] = v_i[g] && (AW'(g) < argc_i);
        CTL_RET:  v_o[g] = v_i[g] && (f_i[g] != cur_frame_i);
        CTL_BR: begin
          v_o[g] = cv[g];
          t_o[g] = ct[g];
          f_o[g] = cf[g];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/belt_push.sv
module belt_push #(
  parameter int BELT_LEN = 8,
  parameter int TAG_W    = 6,
  parameter int FRAME_W  = 4
) (
  input  logic                push_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  logic [FRAME_W-1:0]  frame_i,
  input  logic                v_i [BELT_LEN],
  input  logic [TAG_W-1:0]    t_i [BELT_LEN],
  input  logic [FRAME_W-1:0]  f_i [BELT_LEN],
  output logic                v_o [BELT_LEN],
  output logic [TAG_W-1:0]    t_o [BELT_LEN],
  output logic [FRAME_W-1:0]  f_o [BELT_LEN],
  output logic                evict_v_o,
  output logic [TAG_W-1:0]    evict_t_o
);
  always_comb begin
    v_o[0] = push_i ? 1'b1    : v_i[0];
    t_o[0] = push_i ? tag_i   : t_i[0];
    f_o[0] = push_i ? frame_i : f_i[0];
  end

  for (genvar g = 1; g < BELT_LEN; g++) begin : g_shift
    always_comb begin
      v_o[g] = push_i ? v_i[g-1] : v_i[g];
      t_o[g] = push_i ? t_i[g-1] : t_i[g];
      f_o[g] = push_i ? f_i[g-1] : f_i[g];
    end
  end

  assign evict_v_o = push_i && v_i[BELT_LEN-1];
  assign evict_t_o = t_i[BELT_LEN-1];
endmodule

// File: rtl/belt_tracker.sv
module belt_tracker
  import belt_pkg::*;
#(
  parameter int BELT_LEN = 8,
  parameter int TAG_W    = 6,
  parameter int FRAME_W  = 4,
  localparam int AW      = $clog2(BELT_LEN + 1),
  localparam int PW      = (BELT_LEN > 1) ? $clog2(BELT_LEN) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                drop_valid_i,
  input  logic [TAG_W-1:0]    drop_tag_i,
  input  logic [FRAME_W-1:0]  drop_frame_i,
  input  logic                call_valid_i,
  input  logic [AW-1:0]       call_argc_i,
  input  logic                ret_valid_i,
  input  logic                br_valid_i,
  input  logic [BELT_LEN-1:0] br_keep_i,
  input  logic [PW-1:0]       rd_pos_i,
  output logic                rd_valid_o,
  output logic                rd_err_o,
  output logic [TAG_W-1:0]    rd_tag_o,
  output logic [FRAME_W-1:0]  rd_frame_o,
  output logic                evict_valid_o,
  output logic [TAG_W-1:0]    evict_tag_o,
  output logic [FRAME_W-1:0]  cur_frame_o
);
  logic                v_q [BELT_LEN];
  logic [TAG_W-1:0]    t_q [BELT_LEN];
  logic [FRAME_W-1:0]  f_q [BELT_LEN];
  logic                v_c [BELT_LEN];
  logic [TAG_W-1:0]    t_c [BELT_LEN];
  logic [FRAME_W-1:0]  f_c [BELT_LEN];
  logic                v_d [BELT_LEN];
  logic [TAG_W-1:0]    t_d [BELT_LEN];
  logic [FRAME_W-1:0]  f_d [BELT_LEN];
  logic [FRAME_W-1:0]  cur_frame_q;
  logic                drop_ok;
  logic                ev_v;
  logic [TAG_W-1:0]    ev_t;
  ctl_op_e             op;

  assign op      = pick_ctl(call_valid_i, ret_valid_i, br_valid_i);
  // deeper frame has already returned: dead on arrival
  assign drop_ok = drop_valid_i && (drop_frame_i <= cur_frame_q);

  belt_ctl_stage #(.BELT_LEN(BELT_LEN), .TAG_W(TAG_W), .FRAME_W(FRAME_W)) u_ctl (
    .op_i        (op),
    .argc_i      (call_argc_i),
    .keep_i      (br_keep_i),
    .cur_frame_i (cur_frame_q),
    .v_i         (v_q),
    .t_i         (t_q),
    .f_i         (f_q),
    .v_o         (v_c),
    .t_o         (t_c),
    .f_o         (f_c)
  );

  belt_push #(.BELT_LEN(BELT_LEN), .TAG_W(TAG_W), .FRAME_W(FRAME_W)) u_push (
    .push_i    (drop_ok),
    .tag_i     (drop_tag_i),
    .frame_i   (drop_frame_i),
    .v_i       (v_c),
    .t_i       (t_c),
    .f_i       (f_c),
    .v_o       (v_d),
    .t_o       (t_d),
    .f_o       (f_d),
    .evict_v_o (ev_v),
    .evict_t_o (ev_t)
  );

  for (genvar g = 0; g < BELT_LEN; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[g] <= 1'b0;
        t_q[g] <= '0;
        f_q[g] <= '0;
      end else begin
        v_q[g] <= v_d[g];
        t_q[g] <= t_d[g];
        f_q[g] <= f_d[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_frame_q   <= '0;
      evict_valid_o <= 1'b0;
      evict_tag_o   <= '0;
    end else begin
      evict_valid_o <= ev_v;
      evict_tag_o   <= ev_v ? ev_t : '0;
      if (op == CTL_CALL)
        cur_frame_q <= cur_frame_q + FRAME_W'(1);
      else if (op == CTL_RET && cur_frame_q != '0)
        cur_frame_q <= cur_frame_q - FRAME_W'(1);
    end
  end

  assign cur_frame_o = cur_frame_q;
  assign rd_valid_o  = v_q[rd_pos_i];
  assign rd_err_o    = !v_q[rd_pos_i];
  assign rd_tag_o    = t_q[rd_pos_i];
  assign rd_frame_o  = f_q[rd_pos_i];

  // R2
  a_r2_drop_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_ok && op == CTL_NONE) |=> (v_q[0] && t_q[0] == $past(drop_tag_i)
                                     && f_q[0] == $past(drop_frame_i)));
  // R3
  a_r3_evict_needs_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evict_valid_o) |-> $past(drop_valid_i));
  // R7
  a_r7_doa_no_evict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_valid_i && drop_frame_i > cur_frame_q) |=> !evict_valid_o);
  // R4
  a_r4_call_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_valid_i |=> cur_frame_q == $past(cur_frame_q) + FRAME_W'(1));
  // R5
  a_r5_ret_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !call_valid_i && cur_frame_q != '0)
      |=> cur_frame_q == $past(cur_frame_q) - FRAME_W'(1));
  // R10
  a_r10_br_no_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && !call_valid_i && !ret_valid_i) |=> $stable(cur_frame_q));
endmodule

// File: tb/tb_belt_tracker.sv
module tb_belt_tracker;
  localparam int L  = 8;
  localparam int TW = 6;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drop_v = 0, call_v = 0, ret_v = 0, br_v = 0;
  logic [TW-1:0] drop_t = '0;
  logic [FW-1:0] drop_f = '0;
  logic [3:0] argc = '0;
  logic [L-1:0] keep = '0;
  logic [2:0] rd_pos = '0;
  logic rd_valid, rd_err, ev_valid;
  logic [TW-1:0] rd_tag, ev_tag;
  logic [FW-1:0] rd_frame, cur_frame;

  int checks = 0, failures = 0;
  int sb[$];
  bit mon_on = 0;
  int m_v[L], m_t[L], m_f[L];
  int m_cur = 0;

  always #10 clk = ~clk;

  belt_tracker #(.BELT_LEN(L), .TAG_W(TW), .FRAME_W(FW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .drop_valid_i(drop_v), .drop_tag_i(drop_t), .drop_frame_i(drop_f),
    .call_valid_i(call_v), .call_argc_i(argc), .ret_valid_i(ret_v),
    .br_valid_i(br_v), .br_keep_i(keep), .rd_pos_i(rd_pos),
    .rd_valid_o(rd_valid), .rd_err_o(rd_err), .rd_tag_o(rd_tag), .rd_frame_o(rd_frame),
    .evict_valid_o(ev_valid), .evict_tag_o(ev_tag), .cur_frame_o(cur_frame)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // encoded as valid*10000 + err*1000 + tag*16 + frame
  task automatic check_all(input string req);
    for (int p = 0; p < L; p++) begin
      int act, exp;
      rd_pos = p[2:0];
      #1;
      act = rd_valid * 10000 + rd_err * 1000 + (rd_valid ? rd_tag * 16 + rd_frame : 0);
      exp = m_v[p] * 10000 + (1 - m_v[p]) * 1000 + (m_v[p] != 0 ? m_t[p] * 16 + m_f[p] : 0);
      chk(act == exp, req, $sformatf("pos%0d", p), act, exp);
    end
  endtask

  task automatic do_op(input bit d, input int tag, input int fr, input bit c, input int ac,
                       input bit r, input bit b, input logic [L-1:0] km, input string req);
    bit doa;
    @(negedge clk);
    drop_v = d; drop_t = tag[TW-1:0]; drop_f = fr[FW-1:0];
    call_v = c; argc = ac[3:0]; ret_v = r; br_v = b; keep = km;
    @(posedge clk);
    #1;
    drop_v = 0; call_v = 0; ret_v = 0; br_v = 0;
    doa = (fr > m_cur);
    if (c) begin
      for (int i = 0; i < L; i++) if (i >= ac) m_v[i] = 0;
      m_cur = (m_cur + 1) % 16;
    end else if (r) begin
      for (int i = 0; i < L; i++) if (m_f[i] == m_cur) m_v[i] = 0;
      if (m_cur > 0) m_cur--;
    end else if (b) begin
      int nv[L], nt[L], nf[L];
      int n = 0;
      for (int i = 0; i < L; i++) begin nv[i] = 0; nt[i] = 0; nf[i] = 0; end
      for (int i = 0; i < L; i++)
        if (m_v[i] != 0 && km[i]) begin nv[n] = 1; nt[n] = m_t[i]; nf[n] = m_f[i]; n++; end
      m_v = nv; m_t = nt; m_f = nf;
    end
    if (d && !doa) begin
      if (m_v[L-1] != 0) sb.push_back(m_t[L-1]);
      for (int i = L - 1; i > 0; i--) begin m_v[i] = m_v[i-1]; m_t[i] = m_t[i-1]; m_f[i] = m_f[i-1]; end
      m_v[0] = 1; m_t[0] = tag; m_f[0] = fr;
    end
    chk(cur_frame == m_cur[FW-1:0], req, "cur_frame", cur_frame, m_cur);
    check_all(req);
  endtask

  // eviction monitor (R3, R7)
  always @(negedge clk) begin
    if (mon_on) begin
      if (ev_valid) begin
        if (sb.size() == 0) chk(0, "R3", "unexpected eviction tag", ev_tag, -1);
        else begin
          int e;
          e = sb.pop_front();
          chk(ev_tag == e[TW-1:0], "R3", "evict tag", ev_tag, e);
        end
      end else if (sb.size() > 0) begin
        int e;
        e = sb.pop_front();
        chk(0, "R3", "missing eviction tag", -1, e);
      end
    end
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < L; i++) begin m_v[i] = 0; m_t[i] = 0; m_f[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(cur_frame == 0, "R1", "cur_frame", cur_frame, 0);
    chk(ev_valid == 0, "R1", "evict_valid", ev_valid, 0);
    check_all("R1");
    @(negedge clk);
    rst_n = 1;
    mon_on = 1;
    // R2/R3 fill past the end
    for (int k = 1; k <= 10; k++) do_op(1, k, 0, 0, 0, 0, 0, '0, (k > 8) ? "R3" : "R2");
    // R4 call keeps three args
    do_op(0, 0, 0, 1, 3, 0, 0, '0, "R4");
    // R8 caller result during callee
    do_op(1, 20, 0, 0, 0, 0, 0, '0, "R8");
    do_op(1, 21, 1, 0, 0, 0, 0, '0, "R2");
    // R7 dead on arrival
    do_op(1, 30, 2, 0, 0, 0, 0, '0, "R7");
    do_op(1, 31, 5, 0, 0, 0, 0, '0, "R7");
    // R6 branch with compaction
    do_op(0, 0, 0, 0, 0, 0, 1, 8'b0010_0101, "R6");
    for (int k = 40; k < 48; k++) do_op(1, k, 1, 0, 0, 0, 0, '0, "R3");
    do_op(0, 0, 0, 0, 0, 0, 1, 8'b1100_1010, "R6");
    // R10 call beats branch, drop applied after, DOA judged on old frame
    do_op(1, 50, 1, 1, 2, 0, 1, 8'b1111_1111, "R10");
    do_op(1, 51, 2, 0, 0, 0, 0, '0, "R10");
    // R10 return beats branch
    do_op(1, 52, 2, 0, 0, 1, 1, 8'b0000_0000, "R10");
    // R5 returns and floor at zero
    do_op(0, 0, 0, 0, 0, 1, 0, '0, "R5");
    do_op(0, 0, 0, 0, 0, 1, 0, '0, "R5");
    // R9 branch discards everything, all lookups error
    do_op(0, 0, 0, 0, 0, 0, 1, 8'b0000_0000, "R9");
    do_op(1, 60, 0, 0, 0, 0, 0, '0, "R9");
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R3", "pending evictions", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule